// File: doc/BRIEF.md
# Word-Addressed Control Register Bank with Bit-Operation Aliases

This block is a bank of 32-bit control registers on a simple word-access bus. Some registers are "aliased". Each of these takes four consecutive word addresses. The first is the register itself. The other three apply a bit operation with the write data: OR-in, clear-where-one, or invert-where-one. Software can therefore raise, drop or flip single control bits with one write and no read-modify-write sequence. Reads at any of the four addresses return the same stored value.

The remaining registers are plain read/write words placed after the aliased groups. An aliased register can be marked as holding a status bit that always reads as 1. That bit is set at reset and no write can clear it.

Every access is checked for a legal width and alignment. A bad access, or one to an unmapped word, is contained: it returns zero and changes no state. Every request is answered exactly one cycle later.

Top module: `regbank_sca`

## Requirements
- R1: The word index is the byte address shifted right by two. Aliased register g (0 to N_ALIAS-1) occupies words 4g to 4g+3, where word offset 0 is the register, 1 is set, 2 is clear and 3 is toggle. Plain register p occupies word 4*N_ALIAS+p.
- R2: A write to an aliased register's own word replaces its whole value.
- R3: A write to the set alias (word offset 1) ORs the write data into the register.
- R4: A write to the clear alias (word offset 2) clears every register bit that is 1 in the write data.
- R5: A write to the toggle alias (word offset 3) XORs the write data into the register.
- R6: A read at any of the three alias words returns the register's current value.
- R7: A plain register is replaced completely by a write and returns the stored value on a read.
- R8: At reset every register takes its reset value. On registers flagged in LOCK_MASK, bit LOCK_BIT (31 by default) is forced to 1 at reset and stays 1 through every write and alias operation.
- R9: The size code counts bytes as 2^size (0=1, 1=2, 2=4, 3=8 bytes). Only size 2 with address bits [1:0] equal to 0 is legal. An illegal access returns read data 0 with bus_err=1 and modifies no register.
- R10: A legal access to a word that maps to no register returns read data 0 with bus_err=0, and a write there changes no register.
- R11: bus_done, bus_err and bus_rdata are valid in the cycle after the request cycle. A write is seen by a read issued in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_size | input | 2 | Access size code, 2^size bytes |
| bus_wr | input | 1 | Write request |
| bus_wdata | input | DW (32) | Write data |
| bus_rd | input | 1 | Read request |
| bus_rdata | output | DW (32) | Read data, valid with bus_done |
| bus_done | output | 1 | Response strobe, one cycle after a request |
| bus_err | output | 1 | Illegal size or alignment, valid with bus_done |

## Verification
The response registers load on the edge that samples the request, so bus_done, bus_err and bus_rdata are due exactly one cycle after the request cycle. Register state changes on that same edge. The scoreboard records the request cycle for each expected item. The monitor samples on the falling edge, pops the oldest item whenever bus_done is seen, and fails any response whose cycle is not the request cycle plus one. Back-to-back write-then-read pairs check that the new value is already visible to a read issued in the next cycle.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_TOG   = 2'd3
  } op_e;

  localparam logic [1:0] SIZE_WORD = 2'd2;
endpackage

// File: rtl/regbank_decode.sv
module regbank_decode
  import regbank_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int N_ALIAS = 4,
  parameter int N_PLAIN = 4,
  parameter int IDX_W   = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic              legal,
  output logic              hit,
  output logic [IDX_W-1:0]  idx,
  output op_e               op
);
  localparam int WW          = ADDR_W - 2;
  localparam int ALIAS_WORDS = 4 * N_ALIAS;

  logic [WW-1:0] word;
  int            w_int;

  assign word  = addr[ADDR_W-1:2];
  assign w_int = int'(word);
  assign legal = (size == SIZE_WORD) && (addr[1:0] == 2'b00);

  always_comb begin
    hit = 1'b0;
    idx = '0;
    op  = OP_WRITE;
    if (w_int < ALIAS_WORDS) begin
      hit = 1'b1;
      idx = IDX_W'(w_int / 4);
      op  = op_e'(word[1:0]);
    end else if (w_int < ALIAS_WORDS + N_PLAIN) begin
      hit = 1'b1;
      idx = IDX_W'(w_int - ALIAS_WORDS + N_ALIAS);
    end
  end
endmodule

// File: rtl/regbank_cell.sv
module regbank_cell
  import regbank_pkg::*;
#(
  parameter int            DW       = 32,
  parameter logic [DW-1:0] RST      = '0,
  parameter bit            HAS_LOCK = 1'b0,
  parameter int            LOCK_BIT = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  op_e           op,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam logic [DW-1:0] FORCE1 = HAS_LOCK ? (DW'(1) << LOCK_BIT) : '0;

  logic [DW-1:0] raw_nxt;
  logic [DW-1:0] q_nxt;

  always_comb begin
    unique case (op)
      OP_SET:  raw_nxt = q | wdata;
      OP_CLR:  raw_nxt = q & ~wdata;
      OP_TOG:  raw_nxt = q ^ wdata;
      default: raw_nxt = wdata;
    endcase
    q_nxt = raw_nxt | FORCE1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST | FORCE1;
    else if (we) q <= q_nxt;
  end

  generate
    if (HAS_LOCK) begin : g_lock_chk
      // R8: status bit never reads 0 after reset
      a_r8_lock_held: assert property (@(posedge clk) disable iff (!rst_n)
        q[LOCK_BIT] == 1'b1);
    end
  endgenerate
endmodule

// File: rtl/regbank_sca.sv
module regbank_sca
  import regbank_pkg::*;
#(
  parameter int                    DW        = 32,
  parameter int                    ADDR_W    = 8,
  parameter int                    N_ALIAS   = 4,
  parameter int                    N_PLAIN   = 4,
  parameter int                    LOCK_BIT  = 31,
  parameter logic [N_ALIAS-1:0]    LOCK_MASK = 4'b0101,
  parameter logic [N_ALIAS*DW-1:0] ALIAS_RST = {32'h0000_1042, 32'h0001_0000,
                                               32'h0000_2000, 32'h0001_3001},
  parameter logic [N_PLAIN*DW-1:0] PLAIN_RST = {32'h0000_0000, 32'h1234_0000,
                                               32'hFFFF_FFFF, 32'h0000_0010}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_rd,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_done,
  output logic              bus_err
);
  localparam int NREG  = N_ALIAS + N_PLAIN;
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

  logic                      legal, hit, access;
  logic [IDX_W-1:0]          idx;
  op_e                       op;
  logic [NREG-1:0]           we;
  logic [NREG-1:0][DW-1:0]   q_all;
  logic [DW-1:0]             rdata_nxt;

  regbank_decode #(
    .ADDR_W(ADDR_W), .N_ALIAS(N_ALIAS), .N_PLAIN(N_PLAIN), .IDX_W(IDX_W)
  ) u_dec (
    .addr(bus_addr), .size(bus_size), .legal(legal), .hit(hit),
    .idx(idx), .op(op)
  );

  genvar i;
  generate
    for (i = 0; i < NREG; i++) begin : g_reg
      assign we[i] = bus_wr && legal && hit && (idx == IDX_W'(i));
      if (i < N_ALIAS) begin : g_alias
        regbank_cell #(
          .DW(DW), .RST(ALIAS_RST[i*DW +: DW]),
          .HAS_LOCK(LOCK_MASK[i]), .LOCK_BIT(LOCK_BIT)
        ) u_cell (
          .clk(clk), .rst_n(rst_n), .we(we[i]), .op(op),
          .wdata(bus_wdata), .q(q_all[i])
        );
      end else begin : g_plain
        regbank_cell #(
          .DW(DW), .RST(PLAIN_RST[(i-N_ALIAS)*DW +: DW]),
          .HAS_LOCK(1'b0), .LOCK_BIT(LOCK_BIT)
        ) u_cell (
          .clk(clk), .rst_n(rst_n), .we(we[i]), .op(OP_WRITE),
          .wdata(bus_wdata), .q(q_all[i])
        );
      end
    end
  endgenerate

  assign access    = bus_rd | bus_wr;
  assign rdata_nxt = (bus_rd && legal && hit) ? q_all[idx] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_done  <= 1'b0;
      bus_err   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_done <= access;
      if (access) begin
        bus_err   <= ~legal;
        bus_rdata <= rdata_nxt;
      end
    end
  end

  // R11: every request is answered in the following cycle
  a_r11_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    access |=> bus_done);
  // R9: an illegal write leaves every register as it was
  a_r9_err_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !legal) |=> $stable(q_all));
  // R9: an error response carries zero data
  a_r9_err_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !legal) |=> (bus_err && bus_rdata == '0));
  // R10: a legal read of an unmapped word answers zero without error
  a_r10_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && legal && !hit) |=> (!bus_err && bus_rdata == '0));
  // R10: a write to an unmapped word changes no register
  a_r10_miss_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && legal && !hit) |=> $stable(q_all));
endmodule

// File: tb/tb_regbank_sca.sv
module tb_regbank_sca;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic [1:0]  bus_size;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_done, bus_err;

  always #4 clk = ~clk;  // 125 MHz

  regbank_sca dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .bus_done(bus_done), .bus_err(bus_err)
  );

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit ended  = 0;

  logic [31:0] model [8];
  logic [31:0] q_data [$];
  logic        q_err  [$];
  int          q_cyc  [$];
  string       q_req  [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // drive one request at a falling edge and queue what it must return
  task automatic drive(input bit rd, input bit wr, input logic [7:0] a,
                       input logic [1:0] sz, input logic [31:0] wd,
                       input string req);
    bit          legal, hit;
    int          w, ix, op;
    logic [31:0] exp_d, nv;
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_size = sz; bus_wdata = wd;
    legal = (sz == 2'd2) && (a[1:0] == 2'b00);
    w = int'(a >> 2);
    hit = 1; ix = 0; op = 0;
    if (w < 16)      begin ix = w / 4; op = w % 4; end
    else if (w < 20) ix = 4 + w - 16;
    else             hit = 0;
    exp_d = (rd && legal && hit) ? model[ix] : 32'h0;
    if (wr && legal && hit) begin
      case (op)
        1:       nv = model[ix] | wd;
        2:       nv = model[ix] & ~wd;
        3:       nv = model[ix] ^ wd;
        default: nv = wd;
      endcase
      if (ix == 0 || ix == 2) nv[31] = 1'b1;
      model[ix] = nv;
    end
    q_data.push_back(exp_d);
    q_err.push_back(!legal);
    q_cyc.push_back(cyc);
    q_req.push_back(req);
  endtask

  task automatic idle();
    @(negedge clk);
    bus_rd = 0; bus_wr = 0; bus_addr = '0; bus_size = 2'd2; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, input string req);
    drive(1, 0, a, 2'd2, 32'h0, req); idle();
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string req);
    drive(0, 1, a, 2'd2, d, req); idle();
  endtask

  // monitor: pop and compare each response as it appears
  always @(negedge clk) begin
    if (rst_n && bus_done) begin
      if (q_data.size() == 0) begin
        check(0, "R11 unexpected response", {31'h0, bus_done}, 32'h0);
      end else begin
        logic [31:0] ed; logic ee; int ec; string er;
        ed = q_data.pop_front(); ee = q_err.pop_front();
        ec = q_cyc.pop_front();  er = q_req.pop_front();
        check(bus_rdata == ed, {er, " rdata"}, bus_rdata, ed);
        check(bus_err == ee, {er, " err"}, {31'h0, bus_err}, {31'h0, ee});
        check(cyc == ec + 1, "R11 latency", cyc, ec + 1);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    model[0] = 32'h8001_3001; model[1] = 32'h0000_2000;
    model[2] = 32'h8001_0000; model[3] = 32'h0000_1042;
    model[4] = 32'h0000_0010; model[5] = 32'hFFFF_FFFF;
    model[6] = 32'h1234_0000; model[7] = 32'h0000_0000;
    rst_n = 0; bus_rd = 0; bus_wr = 0; bus_addr = '0; bus_size = 2'd2;
    bus_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(bus_done == 0, "R8 reset done", {31'h0, bus_done}, 32'h0);
    check(bus_rdata == 0, "R8 reset rdata", bus_rdata, 32'h0);
    rst_n = 1;

    // R8: reset values, lock bit on registers 0 and 2
    for (int g = 0; g < 4; g++) rd(8'(g * 16), "R8");
    for (int p = 0; p < 4; p++) rd(8'(64 + p * 4), "R8");
    // R6: alias words read the base value
    for (int k = 1; k < 4; k++) rd(8'(k * 4), "R6");

    // R2..R5 on unlocked register 1 (base byte 0x10)
    wr(8'h10, 32'hA5A5_0F0F, "R2"); rd(8'h10, "R2");
    wr(8'h14, 32'h0000_F000, "R3"); rd(8'h10, "R3");
    wr(8'h18, 32'hA000_000F, "R4"); rd(8'h10, "R4");
    wr(8'h1C, 32'hFFFF_0000, "R5"); rd(8'h1C, "R5 R6");
    rd(8'h14, "R6"); rd(8'h18, "R6");

    // R8: locked register 0 keeps bit 31
    wr(8'h00, 32'h0000_0000, "R8"); rd(8'h00, "R8");
    wr(8'h08, 32'h8000_0000, "R8"); rd(8'h00, "R8");
    wr(8'h0C, 32'h8000_0001, "R8"); rd(8'h00, "R8");
    // unlocked register 3 can move bit 31
    wr(8'h34, 32'h8000_0000, "R3"); rd(8'h30, "R3");
    wr(8'h38, 32'h8000_0000, "R4"); rd(8'h30, "R4");

    // R1: distinct values per group and plain slot
    for (int g = 0; g < 4; g++) wr(8'(g * 16), 32'h1111_1111 * (g + 1), "R1");
    for (int p = 0; p < 4; p++) wr(8'(64 + p * 4), 32'h0101_0000 * (p + 3), "R1");
    for (int g = 0; g < 4; g++) rd(8'(g * 16), "R1");
    for (int p = 0; p < 4; p++) rd(8'(64 + p * 4), "R1");

    // R7: plain full replace
    wr(8'h40, 32'hDEAD_BEEF, "R7"); rd(8'h40, "R7");
    wr(8'h48, 32'h0000_0001, "R7"); rd(8'h48, "R7");

    // R9: illegal sizes and alignment
    drive(1, 0, 8'h00, 2'd0, 0, "R9"); idle();
    drive(1, 0, 8'h40, 2'd3, 0, "R9"); idle();
    drive(1, 0, 8'h02, 2'd2, 0, "R9"); idle();
    drive(0, 1, 8'h11, 2'd2, 32'hFFFF_FFFF, "R9"); idle();
    drive(0, 1, 8'h44, 2'd1, 32'h0BAD_0BAD, "R9"); idle();
    rd(8'h10, "R9"); rd(8'h44, "R9");

    // R10: unmapped words
    rd(8'h60, "R10"); rd(8'hFC, "R10");
    wr(8'h60, 32'hFFFF_FFFF, "R10"); rd(8'h60, "R10");
    for (int p = 0; p < 4; p++) rd(8'(64 + p * 4), "R10");

    // R11: back-to-back write then read
    drive(0, 1, 8'h4C, 2'd2, 32'hCAFE_F00D, "R11");
    drive(1, 0, 8'h4C, 2'd2, 0, "R11");
    drive(0, 1, 8'h24, 2'd2, 32'h0000_00F0, "R11");
    drive(1, 0, 8'h20, 2'd2, 0, "R11");
    idle();
    repeat (3) @(negedge clk);
    check(q_data.size() == 0, "R11 pending responses", q_data.size(), 0);
    finish_run();
  end
endmodule